// File: doc/BRIEF.md
# Indexed Indirect Effective-Address Sequencer

This unit turns the addressing part of a 36-bit instruction word into a final 18-bit effective address. It takes an address constant, optionally adds the low half of one of sixteen general registers to it, and, when the word asks for indirection, reads the word at the computed address and repeats the same calculation on that word. The chain ends when a word with a clear indirect flag is reached. Locations 0 to 15 name the general registers, so a hop into that range is served from the register file and never reaches memory.

The sequencer sits between instruction fetch and execution. A start strobe hands it a word. It uses a single combinational register-file read port and a memory read port with a request/valid handshake. When the address is ready it gives a one-cycle done pulse. A parameter caps the number of indirect hops, so a word that points at itself cannot hang the pipeline. When the cap is reached, an error flag is raised together with done.

Top module: `ea_sequencer`

## Requirements
- R1: Addressing fields use little-endian positions: bit [22] is the indirect flag, bits [21:18] are the index register number and bits [17:0] are the address constant. Bits [35:23] have no effect. With a zero index number and a clear indirect flag, the result equals the constant.
- R2: With a nonzero index number, the result is the constant plus bits [17:0] of that register, modulo 2^18. Register bits [35:18] have no effect, and register 0 is never read as an index.
- R3: With the indirect flag set, the word at the computed address is fetched and bits [22:0] of it are decoded as in R1 and R2. This repeats until a fetched word has a clear indirect flag, and the address computed from that word is the result.
- R4: An indirect hop to an address below 16 reads register file entry address[3:0] and raises no memory request.
- R5: A memory hop raises memReq with memAddr equal to the computed address. Both are held unchanged until memValid is seen, and the fetched word is taken from memData in that cycle.
- R6: At most MAX_HOPS indirect fetches are made. If the word decoded after MAX_HOPS fetches still has its indirect flag set, chainError is asserted with done and effAddr holds the last computed address. A chain of exactly MAX_HOPS fetches completes without error.
- R7: done is high for exactly one cycle. It is high in the cycle that follows the second rising edge after start is sampled, plus 2 cycles per register hop and plus 3 + w cycles per memory hop, where w is the number of cycles memValid trails the request beyond one.
- R8: effAddr and chainError change only when done rises and hold until the next result. A start strobe while a calculation is in progress is ignored.
- R9: After reset, done, memReq, chainError and effAddr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation with instrWord (sampled when idle) |
| instrWord | input | 36 | Instruction word holding the addressing fields |
| regIdx | output | 4 | Register file read index |
| regData | input | 36 | Register file read data for regIdx (combinational) |
| memReq | output | 1 | Memory read request, held until memValid |
| memAddr | output | 18 | Memory read address |
| memValid | input | 1 | Memory read data valid |
| memData | input | 36 | Memory read data |
| effAddr | output | 18 | Final effective address |
| done | output | 1 | One-cycle completion pulse |
| chainError | output | 1 | Hop limit reached on the last result |

## Verification
A direct word completes two edges after start is sampled. Each register hop adds two edges, and each memory hop adds three edges plus any cycles that memValid lags. The bench computes this figure for every scenario and counts negedges from the start strobe until done is seen. A result that arrives one cycle early or late is therefore reported, and the address is checked in the same cycle. The bench also checks on the following negedge that done has fallen, and checks several cycles later that effAddr and chainError have not moved. Memory requests are counted per negedge against the expected number of wait cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INDEX,
    ST_FETCH_WAIT,
    ST_DONE
  } eaState_e;

  typedef struct packed {
    logic loadInstr;   // capture fields from the instruction word
    logic loadFetched; // capture fields from the fetched word
    logic useFetchIdx; // register port addresses the hop target
    logic saveEff;     // keep computed address as hop target
    logic bumpHop;     // count one indirect fetch
    logic finish;      // publish result
    logic flagErr;     // published result carries the limit error
  } eaStrobe_t;
endpackage

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int WORD_W   = 36,
  parameter int IDX_W    = 4,
  parameter int MAX_HOPS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eaStrobe_t         strobe,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [WORD_W-1:0] regData,
  input  logic [WORD_W-1:0] memData,
  output logic [IDX_W-1:0]  regIdx,
  output logic [ADDR_W-1:0] memAddr,
  output logic              curIndirect,
  output logic              atLimit,
  output logic              eIsReg,
  output logic [ADDR_W-1:0] effAddr,
  output logic              chainError
);
  localparam int IND_POS = ADDR_W + IDX_W;
  localparam int FLD_W   = IND_POS + 1;
  localparam int HOP_W   = $clog2(MAX_HOPS + 1);

  logic [IDX_W-1:0]  curX;
  logic [ADDR_W-1:0] curY;
  logic [ADDR_W-1:0] eReg;
  logic [HOP_W-1:0]  hopCnt;
  logic [ADDR_W-1:0] effQ;
  logic              errQ;

  logic [ADDR_W-1:0] idxVal;
  logic [ADDR_W-1:0] sumE;
  logic [FLD_W-1:0]  fetchFld;
  logic              unusedHighBits;

  assign unusedHighBits = ^{instrWord[WORD_W-1:FLD_W], regData[WORD_W-1:FLD_W],
                            memData[WORD_W-1:FLD_W]};

  assign regIdx  = strobe.useFetchIdx ? eReg[IDX_W-1:0] : curX;
  assign idxVal  = (curX != '0) ? regData[ADDR_W-1:0] : '0;
  assign sumE    = curY + idxVal;
  assign eIsReg  = (eReg[ADDR_W-1:IDX_W] == '0);
  assign memAddr = eReg;
  assign atLimit = (hopCnt == HOP_W'(MAX_HOPS));
  assign fetchFld = eIsReg ? regData[FLD_W-1:0] : memData[FLD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIndirect <= 1'b0;
      curX        <= '0;
      curY        <= '0;
      eReg        <= '0;
      hopCnt      <= '0;
      effQ        <= '0;
      errQ        <= 1'b0;
    end else begin
      if (strobe.loadInstr) begin
        curIndirect <= instrWord[IND_POS];
        curX        <= instrWord[IND_POS-1:ADDR_W];
        curY        <= instrWord[ADDR_W-1:0];
        hopCnt      <= '0;
      end else if (strobe.loadFetched) begin
        curIndirect <= fetchFld[IND_POS];
        curX        <= fetchFld[IND_POS-1:ADDR_W];
        curY        <= fetchFld[ADDR_W-1:0];
      end
      if (strobe.saveEff) eReg <= sumE;
      if (strobe.bumpHop) hopCnt <= hopCnt + 1'b1;
      if (strobe.finish) begin
        effQ <= sumE;
        errQ <= strobe.flagErr;
      end
    end
  end

  assign effAddr    = effQ;
  assign chainError = errQ;
endmodule

// File: rtl/ea_control.sv
module ea_control
  import ea_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      memValid,
  input  logic      curIndirect,
  input  logic      atLimit,
  input  logic      eIsReg,
  output eaStrobe_t strobe,
  output logic      memReq,
  output logic      done
);
  eaState_e state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    memReq    = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadInstr = 1'b1;
          nextState        = ST_INDEX;
        end
      end
      ST_INDEX: begin
        if (!curIndirect) begin
          strobe.finish = 1'b1;
          nextState     = ST_DONE;
        end else if (atLimit) begin
          strobe.finish  = 1'b1;
          strobe.flagErr = 1'b1;
          nextState      = ST_DONE;
        end else begin
          strobe.saveEff = 1'b1;
          strobe.bumpHop = 1'b1;
          nextState      = ST_FETCH_WAIT;
        end
      end
      ST_FETCH_WAIT: begin
        strobe.useFetchIdx = 1'b1;
        if (eIsReg) begin
          strobe.loadFetched = 1'b1;
          nextState          = ST_INDEX;
        end else begin
          memReq = 1'b1;
          if (memValid) begin
            strobe.loadFetched = 1'b1;
            nextState          = ST_INDEX;
          end
        end
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int WORD_W   = 36,
  parameter int IDX_W    = 4,
  parameter int MAX_HOPS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] instrWord,
  output logic [IDX_W-1:0]  regIdx,
  input  logic [WORD_W-1:0] regData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] effAddr,
  output logic              done,
  output logic              chainError
);
  eaStrobe_t strobe;
  logic      curIndirect;
  logic      atLimit;
  logic      eIsReg;

  ea_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memValid(memValid),
    .curIndirect(curIndirect), .atLimit(atLimit), .eIsReg(eIsReg),
    .strobe(strobe), .memReq(memReq), .done(done)
  );

  ea_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .MAX_HOPS(MAX_HOPS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instrWord(instrWord),
    .regData(regData), .memData(memData), .regIdx(regIdx), .memAddr(memAddr),
    .curIndirect(curIndirect), .atLimit(atLimit), .eIsReg(eIsReg),
    .effAddr(effAddr), .chainError(chainError)
  );
endmodule

// File: rtl/ea_checker.sv
module ea_checker #(
  parameter int ADDR_W = 18,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              chainError,
  input logic              memReq,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] effAddr
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_no_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  assert_no_reg_fetch_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[ADDR_W-1:IDX_W] != '0));

  assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chainError) |-> done);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(effAddr) && $stable(chainError)));
endmodule

bind ea_sequencer ea_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .chainError(chainError),
  .memReq(memReq), .memValid(memValid), .memAddr(memAddr), .effAddr(effAddr)
);

// File: tb/tb_ea_sequencer.sv
module tb_ea_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int HOPS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [35:0] instrWord = '0;
  logic [3:0]  regIdx;
  logic [35:0] regData;
  logic        memReq;
  logic [17:0] memAddr;
  logic        memValid = 1'b0;
  logic [35:0] memData = '0;
  logic [17:0] effAddr;
  logic        done;
  logic        chainError;

  logic [35:0] regs [16];
  logic [35:0] mem [256];
  int memDelay = 0;
  int waitCnt = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_sequencer #(.MAX_HOPS(HOPS)) dut (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .regIdx(regIdx), .regData(regData), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .effAddr(effAddr), .done(done),
    .chainError(chainError)
  );

  assign regData = regs[regIdx];

  always @(posedge clk) begin
    if (!memReq || memValid) begin
      memValid <= 1'b0;
      waitCnt  <= 0;
    end else if (waitCnt == memDelay) begin
      memValid <= 1'b1;
      memData  <= mem[memAddr[7:0]];
    end else begin
      waitCnt <= waitCnt + 1;
    end
  end

  function automatic logic [35:0] mk(input logic ind, input logic [3:0] x,
                                     input logic [17:0] y, input logic [12:0] junk);
    return {junk, ind, x, y};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOne(input string req, input logic [35:0] word,
                        input logic [17:0] expAddr, input logic expErr,
                        input int expLat, input int noiseAt,
                        input logic [35:0] noiseWord, input int expReq,
                        input logic [17:0] reqAddr);
    int n = 0;
    int reqCnt = 0;
    int badAddr = 0;
    bit got = 0;
    logic [17:0] keepAddr;
    logic keepErr;
    @(negedge clk);
    start = 1'b1;
    instrWord = word;
    while (n < 300 && !got) begin
      @(negedge clk);
      n++;
      start = (n == noiseAt);
      if (n == noiseAt) instrWord = noiseWord;
      if (memReq) begin
        reqCnt++;
        if (memAddr != reqAddr) badAddr++;
      end
      if (done) got = 1;
    end
    start = 1'b0;
    check(got && n == expLat, req, "done latency", n, expLat);
    check(effAddr == expAddr, req, "effAddr", effAddr, expAddr);
    check(chainError == expErr, req, "chainError", chainError, expErr);
    if (expReq >= 0) begin
      check(reqCnt == expReq, req, "memReq cycles", reqCnt, expReq);
      check(badAddr == 0, req, "memAddr held", badAddr, 0);
    end
    keepAddr = effAddr;
    keepErr = chainError;
    @(negedge clk);
    check(!done, "R7", "done pulse width", done, 0);
    repeat (4) @(negedge clk);
    check(effAddr == keepAddr && chainError == keepErr, "R8", "result hold",
          {keepErr, effAddr}, {keepErr, keepAddr});
  endtask

  task automatic testReset;
    check(!done && !memReq && !chainError && effAddr == '0, "R9", "reset outputs",
          {done, memReq, chainError, effAddr}, 0);
  endtask

  task automatic testDirect;
    regs[0] = 36'h0_0000_0077;
    runOne("R1", mk(1'b0, 4'd0, 18'h12345, 13'h1FFF), 18'h12345, 1'b0, 2, 0, '0, 0, '0);
  endtask

  task automatic testIndexed;
    regs[5] = {18'h3FFFF, 18'h00010};
    runOne("R2", mk(1'b0, 4'd5, 18'h00100, 13'h0AAA), 18'h00110, 1'b0, 2, 0, '0, 0, '0);
  endtask

  task automatic testWrap;
    regs[3] = {18'h00001, 18'h3FFFF};
    runOne("R2", mk(1'b0, 4'd3, 18'h00002, 13'h0), 18'h00001, 1'b0, 2, 0, '0, 0, '0);
  endtask

  task automatic testMemChain;
    regs[2] = 36'h0_0000_0010;
    mem[8'h20] = mk(1'b1, 4'd2, 18'h00030, 13'h1555);
    mem[8'h40] = mk(1'b0, 4'd0, 18'h00777, 13'h1FFF);
    runOne("R3", mk(1'b1, 4'd0, 18'h00020, 13'h0), 18'h00777, 1'b0, 8, 0, '0, -1, '0);
  endtask

  task automatic testRegAlias;
    regs[7] = mk(1'b0, 4'd0, 18'h00555, 13'h1234);
    mem[8'h07] = mk(1'b0, 4'd0, 18'h00BAD, 13'h0);
    runOne("R4", mk(1'b1, 4'd0, 18'h00007, 13'h0), 18'h00555, 1'b0, 4, 0, '0, 0, '0);
  endtask

  task automatic testSlowMem;
    memDelay = 3;
    mem[8'h50] = mk(1'b0, 4'd0, 18'h00099, 13'h0);
    runOne("R5", mk(1'b1, 4'd0, 18'h00050, 13'h0), 18'h00099, 1'b0, 8, 0, '0, 5, 18'h00050);
    memDelay = 0;
  endtask

  task automatic testSelfLoop;
    mem[8'h60] = mk(1'b1, 4'd0, 18'h00060, 13'h0);
    runOne("R6", mk(1'b1, 4'd0, 18'h00060, 13'h0), 18'h00060, 1'b1, 2 + 3*HOPS, 0, '0, -1, '0);
  endtask

  task automatic testExactLimit;
    mem[8'h70] = mk(1'b1, 4'd0, 18'h00071, 13'h0);
    mem[8'h71] = mk(1'b1, 4'd0, 18'h00072, 13'h0);
    mem[8'h72] = mk(1'b1, 4'd0, 18'h00073, 13'h0);
    mem[8'h73] = mk(1'b0, 4'd0, 18'h00ABC, 13'h0);
    runOne("R6", mk(1'b1, 4'd0, 18'h00070, 13'h0), 18'h00ABC, 1'b0, 2 + 3*HOPS, 0, '0, -1, '0);
  endtask

  task automatic testBusyStart;
    mem[8'h50] = mk(1'b0, 4'd0, 18'h00099, 13'h0);
    runOne("R8", mk(1'b1, 4'd0, 18'h00050, 13'h0), 18'h00099, 1'b0, 5, 2,
           mk(1'b0, 4'd0, 18'h01111, 13'h0), 2, 18'h00050);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirect();
    testIndexed();
    testWrap();
    testMemChain();
    testRegAlias();
    testSlowMem();
    testSelfLoop();
    testExactLimit();
    testBusyStart();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule